// File: doc/BRIEF.md
# Aligned Binary Clock Divider Bank

This block turns one input clock into a set of derived clocks at the input rate divided by 2, 4 and 8 (by default). Every derived clock is one bit of a single binary down-counter stepped by the input clock. A slower output therefore never moves except on the same input edge as the next faster one, and the shared edges coincide.

A run request input starts and stops the bank. It is sampled on the falling input edge, so the counter's effective clock is only opened or closed while the input clock is low. The counter also only parks at the phase where every output is low. As a result, starting or stopping never shortens a high pulse on any output.

An asynchronous master reset clears the counter and the run flop. Several banks can then be released together and stay in phase.

Top module: `clk_div_bank`

## Requirements
- R1: While running, `div_clk_o` is the phase of a binary down-counter that steps by one on every rising input edge: 7, 6, 5, ... 0, 7 for the default width. Bit k therefore toggles with a period of 2^(k+1) input periods.
- R2: `run_req_i` is sampled only on the falling input edge. A request that rises after a falling edge takes effect on the second rising edge after it. A request pulse that spans no falling edge has no effect.
- R3: When the bank starts from the idle phase, all outputs rise together on one input rising edge, going from all-zero to all-one. This applies after reset release and after every re-enable.
- R4: Every high pulse on output bit k lasts exactly 2^k input periods, even when the run request is dropped mid-cycle. Every low time lasts at least 2^k input periods.
- R5: After the run request is dropped, the counter keeps stepping until it reaches the all-zero phase. It then holds there, and all outputs stay low and stable.
- R6: When the run request is raised again, division resumes from the held all-zero phase with no partial pulse.
- R7: `rst_async_i` is active high and asynchronous. It drives all outputs low at once, without a clock edge, and keeps them low while asserted.
- R8: The run request is active high. A request tied or pulled low keeps the bank idle with all outputs low.
- R9: Any change of output bit k+1 happens on the same input edge as a rising edge of bit k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_async_i | input | 1 | Asynchronous active-high master reset |
| run_req_i | input | 1 | Active-high run request, sampled on the falling clock edge |
| div_clk_o | output | STAGES | Bit k is the input clock divided by 2^(k+1) |

## Verification
The bank is tried with four kinds of run request. A request held low after reset shows that the bank stays idle. A request held high shows the full count sequence and the joint rising edge. Requests dropped at a full phase and at a partial phase show whether stopping waits for all outputs to be low instead of cutting a pulse. A request changed just after a falling edge, or pulsed between two falling edges, shows that sampling happens on the negative edge. A long stretch of random request toggling then measures every high and low run and every slow-output edge. This separates a correct bank from one that truncates pulses or lets stages drift apart.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;

    // The counter may step when running, or when it has not yet reached
    // the all-low parking phase.
    function automatic logic may_step(input logic run, input logic at_idle);
        return run || !at_idle;
    endfunction

endpackage

// File: rtl/clk_div_run_sync.sv
module clk_div_run_sync (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_req_i,
    output logic run_o
);

    typedef struct packed {
        logic run;
    } run_state_t;

    run_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.run = run_req_i;
    end

    // Captured on the falling edge: the gate only changes while clk is low.
    always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign run_o = st_q.run;

endmodule

// File: rtl/clk_div_counter.sv
module clk_div_counter #(
    parameter int STAGES = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              run_i,
    output logic [STAGES-1:0] phase_o
);

    localparam logic [STAGES-1:0] PHASE_IDLE = '0;
    localparam logic [STAGES-1:0] PHASE_STEP = {{(STAGES-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [STAGES-1:0] phase;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clk_div_pkg::may_step(run_i, st_q.phase == PHASE_IDLE)) begin
            st_d.phase = st_q.phase - PHASE_STEP;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign phase_o = st_q.phase;

endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank #(
    parameter int STAGES = 3
) (
    input  logic              clk_in,
    input  logic              rst_async_i,
    input  logic              run_req_i,
    output logic [STAGES-1:0] div_clk_o
);

    logic              run_q;
    logic [STAGES-1:0] phase;

    clk_div_run_sync u_run (
        .clk_i     (clk_in),
        .rst_i     (rst_async_i),
        .run_req_i (run_req_i),
        .run_o     (run_q)
    );

    clk_div_counter #(.STAGES(STAGES)) u_cnt (
        .clk_i   (clk_in),
        .rst_i   (rst_async_i),
        .run_i   (run_q),
        .phase_o (phase)
    );

    assign div_clk_o = phase;

endmodule

// File: rtl/clk_div_bank_chk.sv
module clk_div_bank_chk #(
    parameter int STAGES = 3
) (
    input logic              clk_in,
    input logic              rst_async_i,
    input logic              run_q,
    input logic [STAGES-1:0] div_clk_o
);

    always @(posedge clk_in) begin
        if (rst_async_i) begin
            AST_RESET_LOW: assert (div_clk_o == '0); // R7
        end
    end

    AST_FASTEST_TOGGLES: assert property (@(posedge clk_in) disable iff (rst_async_i)
        (run_q || div_clk_o != '0) |=> (div_clk_o[0] != $past(div_clk_o[0]))); // R1

    AST_JOINT_RISE: assert property (@(posedge clk_in) disable iff (rst_async_i)
        $rose(div_clk_o[STAGES-1]) |-> (div_clk_o == '1)); // R3

    AST_PARKED_STABLE: assert property (@(posedge clk_in) disable iff (rst_async_i)
        (!run_q && div_clk_o == '0) |=> (div_clk_o == '0)); // R5

    for (genvar k = 0; k < STAGES - 1; k++) begin : g_link
        AST_EDGE_LINK: assert property (@(posedge clk_in) disable iff (rst_async_i)
            !$stable(div_clk_o[k+1]) |-> $rose(div_clk_o[k])); // R9
    end

endmodule

bind clk_div_bank clk_div_bank_chk #(.STAGES(STAGES)) u_chk (
    .clk_in      (clk_in),
    .rst_async_i (rst_async_i),
    .run_q       (run_q),
    .div_clk_o   (div_clk_o)
);

// File: tb/clk_div_bank_tb.sv
`timescale 1ns/1ps
module clk_div_bank_tb;

    localparam int STAGES = 3;

    logic              clk_in = 1'b0;
    logic              rst_async_i = 1'b1;
    logic              run_req_i = 1'b0;
    logic [STAGES-1:0] div_clk_o;

    int vectors = 0;
    int miscompares = 0;

    clk_div_bank #(.STAGES(STAGES)) u_dut (
        .clk_in      (clk_in),
        .rst_async_i (rst_async_i),
        .run_req_i   (run_req_i),
        .div_clk_o   (div_clk_o)
    );

    always #4 clk_in = ~clk_in;   // 125 MHz

    task automatic check(input string req, input logic [STAGES-1:0] exp);
        vectors++;
        if (div_clk_o !== exp) begin
            miscompares++;
            $display("FAIL %s: div_clk_o=%b expected %b at %0t", req, div_clk_o, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp, input bit at_least);
        vectors++;
        if (at_least ? (act < exp) : (act != exp)) begin
            miscompares++;
            $display("FAIL %s: measured %0d expected %s%0d at %0t", req, act,
                     at_least ? ">=" : "", exp, $time);
        end
    endtask

    // Lands 1 ns after a rising edge: outputs settled, falling edge 3 ns away.
    task automatic tick();
        @(posedge clk_in);
        #1;
    endtask

    task automatic t_reset_state();
        tick();
        check("R7 reset state", '0);
        tick();
        check("R7 reset held", '0);
    endtask

    task automatic t_tied_low();
        rst_async_i = 1'b0;
        for (int i = 0; i < 12; i++) begin
            tick();
            check("R8 request low keeps idle", '0);
        end
    endtask

    task automatic t_first_edge();
        run_req_i = 1'b1;   // before the falling edge -> next rising edge
        tick();
        check("R3 joint rise after reset", '1);
    endtask

    task automatic t_count_sequence();
        for (int i = 1; i <= 16; i++) begin
            tick();
            check("R1 down-count phase", STAGES'(7 - i));
        end
    endtask

    task automatic t_drop_at_full();
        run_req_i = 1'b0;   // phase is all-one here
        for (int i = 1; i <= 7; i++) begin
            tick();
            check("R4 pulse completes after drop", STAGES'(7 - i));
        end
        for (int i = 0; i < 8; i++) begin
            tick();
            check("R5 parked low", '0);
        end
    endtask

    task automatic t_resume_and_mid_drop();
        run_req_i = 1'b1;
        tick();
        check("R6 resume from parked phase", '1);
        for (int i = 1; i <= 4; i++) begin
            tick();
            check("R6 resumed count", STAGES'(7 - i));
        end
        run_req_i = 1'b0;   // phase 3: bits 0 and 1 high
        tick(); check("R4 mid drop", 3'd2);
        tick(); check("R4 mid drop", 3'd1);
        tick(); check("R4 mid drop", 3'd0);
        tick(); check("R5 parked after mid drop", 3'd0);
    endtask

    task automatic t_negedge_sampling();
        @(negedge clk_in);
        #1 run_req_i = 1'b1;   // rises just after a falling edge
        tick();
        check("R2 not seen before next falling edge", '0);
        tick();
        check("R2 seen one edge later", '1);
        run_req_i = 1'b0;
        for (int i = 0; i < 9; i++) tick();
        check("R5 back to parked", '0);
        // pulse that spans no falling edge
        @(negedge clk_in);
        #1 run_req_i = 1'b1;
        @(posedge clk_in);
        #1 run_req_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R2 pulse between falling edges ignored", '0);
        end
    endtask

    task automatic t_async_reset();
        run_req_i = 1'b1;
        tick();
        tick();
        tick();
        #1 rst_async_i = 1'b1;
        #1 check("R7 asynchronous clear", '0);
        tick();
        check("R7 held in reset", '0);
        tick();
        rst_async_i = 1'b0;
        tick();
        check("R3 joint rise after reset release", '1);
    endtask

    task automatic t_random_toggle();
        logic [STAGES-1:0] prev;
        int hi_len [STAGES];
        int lo_len [STAGES];
        run_req_i = 1'b0;
        for (int i = 0; i < 10; i++) tick();
        check("R5 parked before random run", '0);
        prev = div_clk_o;
        for (int k = 0; k < STAGES; k++) begin
            hi_len[k] = 0;
            lo_len[k] = 1 << k;   // parked low already long enough
        end
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 4) == 0) run_req_i = ~run_req_i;
            tick();
            for (int k = 0; k < STAGES; k++) begin
                if (div_clk_o[k]) begin
                    if (!prev[k]) check_int("R4 low time", lo_len[k], 1 << k, 1'b1);
                    hi_len[k]++;
                    lo_len[k] = 0;
                end else begin
                    if (prev[k]) check_int("R4 high time", hi_len[k], 1 << k, 1'b0);
                    lo_len[k]++;
                    hi_len[k] = 0;
                end
            end
            for (int k = 0; k < STAGES - 1; k++) begin
                if (div_clk_o[k+1] != prev[k+1]) begin
                    check_int("R9 slower edge with faster rise",
                              int'({prev[k], div_clk_o[k]}), 1, 1'b0);
                end
            end
            prev = div_clk_o;
        end
    endtask

    initial begin
        t_reset_state();
        t_tied_low();
        t_first_edge();
        t_count_sequence();
        t_drop_at_full();
        t_resume_and_mid_drop();
        t_negedge_sampling();
        t_async_reset();
        t_random_toggle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule